// File: doc/BRIEF.md
# 64-bit Address Phase Sequencer

This block handles the address phase of a PCI-style bus agent that uses 64-bit addresses. It has a master side and a target side.

The master side accepts a 64-bit address and a 4-bit bus command. If the upper 32 bits are zero, it drives one address phase, which saves a bus cycle. Otherwise it drives a two-phase dual address cycle. Phase one carries the low half with the dual-address command code. Phase two carries the high half with the real command. When the master is set up for a 64-bit path, phase one also drives the high half and the real command on the upper lines. A 64-bit target can then decode without waiting for phase two.

The target side watches the address lines. It builds the complete address for one of three cases:
- a single address phase, whose upper half is taken as zero;
- a dual cycle on a 64-bit path, taken whole from phase one;
- a dual cycle on a 32-bit path, joined from two phases.

It compares that address against a base/mask window and gives a one-clock hit pulse with the decoded command. A dual cycle on a 64-bit path therefore hits as early as a single phase does. Either path width works with 64-bit addressing.

Top module: `addr64_seq`

## Requirements
- R1: After reset, `req_ready` is 1, while `addr_phase`, all master bus outputs and `hit` are 0.
- R2: A request whose upper 32 bits are zero drives exactly one `addr_phase` cycle, starting the cycle after acceptance. In that cycle `m_ad_lo` is the low address half, `m_cbe_lo` is the command, and `m_ad_hi`/`m_cbe_hi` are 0.
- R3: A request whose upper 32 bits are nonzero drives two consecutive `addr_phase` cycles. In the first, `m_ad_lo` is the low half and `m_cbe_lo` is 4'b1101. In the second, `m_ad_lo` is the high half and `m_cbe_lo` is the command.
- R4: If `wide_path` was 1 at acceptance, the first phase of a dual cycle also drives the high half on `m_ad_hi` and the command on `m_cbe_hi`. In every other cycle, `m_ad_hi` and `m_cbe_hi` are 0.
- R5: `req_ready` is 0 while a sequence is in progress. A request presented then is ignored, and the phases in progress keep their values.
- R6: When `mon_valid` is 1 and `mon_cbe_lo` is not 4'b1101, the target forms the address {32'h0, `mon_ad_lo`}. In the next cycle `hit` is 1 exactly when ((address ^ `base`) & `mask`) == 0 and `base[63:32]` == 0. `hit_cmd` is then `mon_cbe_lo` and `hit_addr` is the address.
- R7: A single-phase address never hits when `base[63:32]` is nonzero, whatever the mask.
- R8: When `mon_valid` is 1, `mon_cbe_lo` is 4'b1101 and `mon_wide` is 1, the address is {`mon_ad_hi`, `mon_ad_lo`} and the command is `mon_cbe_hi`. The hit decision comes in the next cycle, and the following second phase causes no further hit.
- R9: When `mon_valid` is 1, `mon_cbe_lo` is 4'b1101 and `mon_wide` is 0, the target keeps `mon_ad_lo`. In the following cycle it forms {`mon_ad_lo`, kept low half} with command `mon_cbe_lo`. The hit decision comes one cycle after that second phase.
- R10: `hit` is a pulse lasting one cycle for each decoded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Master request strobe |
| req_addr | input | 64 | Requested address |
| req_cmd | input | 4 | Requested bus command |
| wide_path | input | 1 | Master uses the 64-bit path |
| req_ready | output | 1 | Master idle, request accepted |
| addr_phase | output | 1 | Master is driving an address phase |
| m_ad_lo | output | 32 | Master lower address lines |
| m_cbe_lo | output | 4 | Master lower command lines |
| m_ad_hi | output | 32 | Master upper address lines |
| m_cbe_hi | output | 4 | Master upper command lines |
| mon_valid | input | 1 | First address phase seen on the bus |
| mon_ad_lo | input | 32 | Observed lower address lines |
| mon_cbe_lo | input | 4 | Observed lower command lines |
| mon_ad_hi | input | 32 | Observed upper address lines |
| mon_cbe_hi | input | 4 | Observed upper command lines |
| mon_wide | input | 1 | Target uses the 64-bit path |
| base | input | 64 | Match window base |
| mask | input | 64 | Match window mask, 1 = bit compared |
| hit | output | 1 | Address hit pulse |
| hit_cmd | output | 4 | Command of the hit |
| hit_addr | output | 64 | Decoded address |
| hit_dual | output | 1 | Hit came from a dual address cycle |

## Verification
The master side is swept over a grid of addresses and commands. The upper halves include zero, one, the top bit alone and all ones, and the grid runs on both path widths. This separates the single-phase and dual-phase cases and shows whether the upper lines stay quiet. A request made while the master is busy shows whether the phases in progress stay intact.

The target side receives the same address grid three ways: as single phases, as wide dual cycles and as narrow dual cycles. It does this against a window with a zero upper base and one with a nonzero upper base. The cycle in which the hit arrives separates early decode from joined decode. The nonzero-upper window shows that single phases are rejected.

// File: rtl/addr64_seq.sv
module addr64_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  input  logic [3:0]  req_cmd,
  input  logic        wide_path,
  output logic        req_ready,
  output logic        addr_phase,
  output logic [31:0] m_ad_lo,
  output logic [3:0]  m_cbe_lo,
  output logic [31:0] m_ad_hi,
  output logic [3:0]  m_cbe_hi,
  input  logic        mon_valid,
  input  logic [31:0] mon_ad_lo,
  input  logic [3:0]  mon_cbe_lo,
  input  logic [31:0] mon_ad_hi,
  input  logic [3:0]  mon_cbe_hi,
  input  logic        mon_wide,
  input  logic [63:0] base,
  input  logic [63:0] mask,
  output logic        hit,
  output logic [3:0]  hit_cmd,
  output logic [63:0] hit_addr,
  output logic        hit_dual
);
  localparam logic [3:0] DAC_CODE = 4'b1101;

  typedef enum logic [1:0] {M_IDLE, M_FIRST, M_SECOND} mstate_t;
  mstate_t     mst;
  logic [63:0] m_addr;
  logic [3:0]  m_cmd;
  logic        m_dual, m_wide;

  wire accept = req_valid && (mst == M_IDLE);
  wire in_first  = (mst == M_FIRST);
  wire in_second = (mst == M_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst    <= M_IDLE;
      m_addr <= '0;
      m_cmd  <= '0;
      m_dual <= 1'b0;
      m_wide <= 1'b0;
    end else begin
      case (mst)
        M_IDLE: if (accept) begin
          mst    <= M_FIRST;
          m_addr <= req_addr;
          m_cmd  <= req_cmd;
          m_dual <= (req_addr[63:32] != 32'h0);
          m_wide <= wide_path;
        end
        M_FIRST:  mst <= m_dual ? M_SECOND : M_IDLE;
        default:  mst <= M_IDLE;
      endcase
    end
  end

  wire drive_hi = in_first && m_dual && m_wide;

  assign req_ready  = (mst == M_IDLE);
  assign addr_phase = in_first || in_second;
  assign m_ad_lo    = in_first ? m_addr[31:0] : (in_second ? m_addr[63:32] : 32'h0);
  assign m_cbe_lo   = in_first ? (m_dual ? DAC_CODE : m_cmd) : (in_second ? m_cmd : 4'h0);
  assign m_ad_hi    = drive_hi ? m_addr[63:32] : 32'h0;
  assign m_cbe_hi   = drive_hi ? m_cmd : 4'h0;

  logic        t_wait;
  logic [31:0] t_lo;
  logic [63:0] c_addr;
  logic [3:0]  c_cmd;
  logic        c_dual, c_go;

  wire mon_dac = (mon_cbe_lo == DAC_CODE);

  always_comb begin
    c_addr = {32'h0, mon_ad_lo};
    c_cmd  = mon_cbe_lo;
    c_dual = 1'b0;
    c_go   = 1'b0;
    if (t_wait) begin
      c_addr = {mon_ad_lo, t_lo};
      c_dual = 1'b1;
      c_go   = 1'b1;
    end else if (mon_valid && mon_dac && mon_wide) begin
      c_addr = {mon_ad_hi, mon_ad_lo};
      c_cmd  = mon_cbe_hi;
      c_dual = 1'b1;
      c_go   = 1'b1;
    end else if (mon_valid && !mon_dac) begin
      c_go   = 1'b1;
    end
  end

  wire in_window = (((c_addr ^ base) & mask) == 64'h0);
  wire c_match   = c_go && in_window && (c_dual || (base[63:32] == 32'h0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_wait   <= 1'b0;
      t_lo     <= '0;
      hit      <= 1'b0;
      hit_cmd  <= '0;
      hit_addr <= '0;
      hit_dual <= 1'b0;
    end else begin
      t_wait <= !t_wait && mon_valid && mon_dac && !mon_wide;
      if (!t_wait && mon_valid) t_lo <= mon_ad_lo;
      hit <= c_match;
      if (c_match) begin
        hit_cmd  <= c_cmd;
        hit_addr <= c_addr;
        hit_dual <= c_dual;
      end
    end
  end

  AST_DUAL_NEEDS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !$past(addr_phase) && m_cbe_lo == DAC_CODE) |-> (m_ad_lo != 32'h0 || m_addr[63:32] != 32'h0) && m_addr[63:32] != 32'h0); // R2
  AST_DUAL_TWO_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_first && m_dual) |=> (addr_phase && m_ad_lo == $past(m_addr[63:32]))); // R3
  AST_NARROW_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_first || !m_wide) |-> (m_ad_hi == 32'h0 && m_cbe_hi == 4'h0)); // R4
  AST_BUSY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> addr_phase); // R5
  AST_HIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> ($past(mon_valid) || $past(t_wait))); // R9
  AST_SINGLE_UPPER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !hit_dual) |-> (hit_addr[63:32] == 32'h0)); // R7
endmodule

// File: tb/addr64_seq_test.sv
module addr64_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [63:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic        wide_path = 0;
  logic        req_ready, addr_phase;
  logic [31:0] m_ad_lo, m_ad_hi;
  logic [3:0]  m_cbe_lo, m_cbe_hi;
  logic        mon_valid = 0;
  logic [31:0] mon_ad_lo = '0, mon_ad_hi = '0;
  logic [3:0]  mon_cbe_lo = '0, mon_cbe_hi = '0;
  logic        mon_wide = 0;
  logic [63:0] base = '0, mask = '0;
  logic        hit, hit_dual;
  logic [3:0]  hit_cmd;
  logic [63:0] hit_addr;

  int checks = 0, errors = 0;
  localparam logic [3:0] DAC = 4'b1101;

  always #2 clk = ~clk;

  addr64_seq uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] upv(input int i);
    case (i) 0: return 32'h0; 1: return 32'h1; 2: return 32'h8000_0000; default: return 32'hFFFF_FFFF; endcase
  endfunction
  function automatic logic [31:0] lov(input int i);
    case (i) 0: return 32'h8000_0000; 1: return 32'h8ABC_DEF0; 2: return 32'h9000_0000; 3: return 32'hC000_0004; default: return 32'h0000_0010; endcase
  endfunction

  task automatic master_run(input logic [63:0] a, input logic [3:0] c, input bit w, input bit poke);
    bit dual = (a[63:32] != 0);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_cmd = c; wide_path = w;
    step();
    req_valid = poke; req_addr = ~a; req_cmd = ~c; wide_path = ~w;
    chk(addr_phase && !req_ready, "R2/R3 first phase strobe", {62'h0, addr_phase, req_ready}, 64'h2);
    chk(m_ad_lo == a[31:0], "R2/R3 first lo address", m_ad_lo, a[31:0]);
    chk(m_cbe_lo == (dual ? DAC : c), dual ? "R3 first cmd" : "R2 cmd", m_cbe_lo, dual ? DAC : c);
    chk(m_ad_hi == ((dual && w) ? a[63:32] : 0), "R4 upper address", m_ad_hi, (dual && w) ? a[63:32] : 0);
    chk(m_cbe_hi == ((dual && w) ? c : 0), "R4 upper cmd", m_cbe_hi, (dual && w) ? c : 0);
    if (dual) begin
      step();
      req_valid = 0;
      chk(addr_phase && !req_ready, "R3/R5 second phase strobe", {62'h0, addr_phase, req_ready}, 64'h2);
      chk(m_ad_lo == a[63:32], "R3/R5 second address", m_ad_lo, a[63:32]);
      chk(m_cbe_lo == c, "R3/R5 second cmd", m_cbe_lo, c);
      chk(m_ad_hi == 0 && m_cbe_hi == 0, "R4 upper quiet in second", {m_ad_hi, 28'h0, m_cbe_hi}, 0);
    end
    step();
    chk(!addr_phase && req_ready, "R2/R3/R5 back to idle", {62'h0, addr_phase, req_ready}, 64'h1);
  endtask

  function automatic bit exp_hit(input logic [63:0] a, input bit dual);
    return (((a ^ base) & mask) == 0) && (dual || base[63:32] == 0);
  endfunction

  task automatic hit_check(input logic [63:0] a, input logic [3:0] c, input bit dual, input string tag);
    bit e = exp_hit(a, dual);
    chk(hit == e, tag, hit, e);
    if (e) begin
      chk(hit_addr == a, tag, hit_addr, a);
      chk(hit_cmd == c && hit_dual == dual, tag, {hit_cmd, 3'h0, hit_dual}, {c, 3'h0, dual});
    end
  endtask

  task automatic tgt_single(input logic [31:0] lo, input logic [3:0] c);
    mon_valid = 1; mon_ad_lo = lo; mon_cbe_lo = c; mon_ad_hi = 32'h5A5A_5A5A; mon_cbe_hi = DAC; mon_wide = 0;
    step();
    mon_valid = 0; mon_ad_lo = 0; mon_cbe_lo = 0;
    hit_check({32'h0, lo}, c, 0, base[63:32] != 0 ? "R7 single vs upper base" : "R6 single decode");
    step();
    chk(!hit, "R10 pulse ends", hit, 0);
  endtask

  task automatic tgt_dac_wide(input logic [63:0] a, input logic [3:0] c);
    mon_valid = 1; mon_ad_lo = a[31:0]; mon_cbe_lo = DAC; mon_ad_hi = a[63:32]; mon_cbe_hi = c; mon_wide = 1;
    step();
    mon_valid = 0; mon_ad_lo = a[63:32]; mon_cbe_lo = c; mon_ad_hi = 0; mon_cbe_hi = 0;
    hit_check(a, c, 1, "R8 early decode");
    step();
    mon_ad_lo = 0; mon_cbe_lo = 0;
    chk(!hit, "R8/R10 no second hit", hit, 0);
  endtask

  task automatic tgt_dac_narrow(input logic [63:0] a, input logic [3:0] c);
    mon_valid = 1; mon_ad_lo = a[31:0]; mon_cbe_lo = DAC; mon_ad_hi = 0; mon_cbe_hi = 0; mon_wide = 0;
    step();
    mon_valid = 0; mon_ad_lo = a[63:32]; mon_cbe_lo = c;
    chk(!hit, "R9 no hit after first phase", hit, 0);
    step();
    mon_ad_lo = 0; mon_cbe_lo = 0;
    hit_check(a, c, 1, "R9 joined decode");
    step();
    chk(!hit, "R10 pulse ends", hit, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(req_ready && !addr_phase && !hit, "R1 reset state", {61'h0, req_ready, addr_phase, hit}, 64'h4);
    chk(m_ad_lo == 0 && m_cbe_lo == 0 && m_ad_hi == 0 && m_cbe_hi == 0, "R1 bus quiet",
        {m_ad_lo, m_ad_hi}, 0);

    for (int w = 0; w < 2; w++)
      for (int u = 0; u < 4; u++)
        for (int l = 0; l < 5; l++)
          for (int c = 0; c < 16; c += 5)
            master_run({upv(u), lov(l)}, 4'(c), w[0], (u != 0) && (c == 5));

    for (int b = 0; b < 2; b++) begin
      base = b ? 64'h0000_0001_8000_0000 : 64'h0000_0000_8000_0000;
      mask = 64'hFFFF_FFFF_F000_0000;
      for (int u = 0; u < 4; u++)
        for (int l = 0; l < 5; l++) begin
          if (u == 0) tgt_single(lov(l), 4'h6);
          tgt_dac_wide({upv(u), lov(l)}, 4'h7);
          tgt_dac_narrow({upv(u), lov(l)}, 4'hA);
        end
    end
    base = 64'h0000_0002_0000_0000; mask = 64'h0;
    tgt_single(32'h1234_5678, 4'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule